// File: doc/BRIEF.md
# Audio Codec Host Bus Port

This block connects an audio codec to a host over an 8-bit parallel bus. It serves programmed reads and writes of a small register file, and it runs two DMA byte channels: a capture channel that hands finished samples to the host and a playback channel that gathers samples from the host. A sample is four bytes (two 16-bit channels). Each channel holds its request high until a whole sample has moved, so the host's DMA engine can transfer one sample per request.

The host strobes are active low. A cycle takes effect when its strobe is released: the data, address and cycle type seen while the strobe was low are committed on the first clock after release. The block also drives the enable and direction pins of an external bus transceiver straight from the pins. Chip select is only looked at when neither DMA acknowledge is low.

The data bus is split into an input, an output and an output enable, which the pad ring joins into one bidirectional bus.

Top module: `cbi_host_port`

## Requirements
- R1: `cap_req` rises on the clock after `cap_smp_valid` and stays high until the fourth capture byte read has committed; it is low after reset.
- R2: Capture bytes are read in order byte k = sample[8k+7:8k], k = 0..3 (left channel in bits 15:0 low byte first, then the right channel in bits 31:16), on `host_dout` while the read is active.
- R3: `ply_req` is high after reset and whenever the playback buffer is not full; the fourth committed playback write sets `ply_smp_valid` with byte k at bits 8k+7:8k and drops `ply_req`; `ply_take` empties the buffer and raises `ply_req` again.
- R4: A cycle with either DMA acknowledge low is a DMA cycle whatever `bus_cs_n` is; a register cycle needs `bus_cs_n` low and both acknowledges high, otherwise it is ignored.
- R5: A register write commits on release of `bus_wr_n` to the address `bus_addr` (0, 1, 2 are read/write storage), and a register read of that address returns it.
- R6: Address 3 reads {7'b0, overrun}; writing it with bit 0 set clears the overrun bit.
- R7: A capture sample arriving while the previous one is not fully read sets the overrun bit, replaces the old sample and restarts reading at byte 0.
- R8: `xcvr_en_n` is low exactly while a strobe is low together with chip select low or either acknowledge low; it is high otherwise.
- R9: `xcvr_dir` is low exactly while `bus_rd_n` is low together with chip select low or either acknowledge low; it is high otherwise.
- R10: `host_dout_en` is high only during a legal register read or capture DMA read, never during writes or idle.
- R11: A cycle in which both strobes are low at the same time is ignored entirely: no register change, no byte advance, no output drive.
- R12: A playback write while the playback buffer is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_cs_n | input | 1 | Register chip select, active low |
| cap_ack_n | input | 1 | Capture DMA acknowledge, active low |
| ply_ack_n | input | 1 | Playback DMA acknowledge, active low |
| bus_addr | input | 2 | Register address |
| host_din | input | 8 | Data from host |
| host_dout | output | 8 | Data to host |
| host_dout_en | output | 1 | High while the block drives the bus |
| xcvr_en_n | output | 1 | External transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, high host-to-block |
| cap_req | output | 1 | Capture DMA request |
| ply_req | output | 1 | Playback DMA request |
| cap_smp_valid | input | 1 | Converter has a new capture sample |
| cap_smp | input | 32 | Capture sample |
| ply_smp_valid | output | 1 | Full playback sample available |
| ply_smp | output | 32 | Playback sample |
| ply_take | input | 1 | Converter consumed the playback sample |

## Verification
Transceiver pins, `host_dout` and `host_dout_en` are combinational from the pins, so the bench samples them one clock after lowering a strobe, still inside the active cycle. Committed effects (register contents, byte counters, `cap_req`, `ply_req`, overrun, playback sample) change on the first clock edge after strobe release, and the bench checks them at the falling edge after that edge. `cap_req` and `ply_req` after a converter pulse are due one edge later and are likewise checked at the next falling edge.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
    typedef enum logic [2:0] {
        CYC_NONE,
        CYC_REG_RD,
        CYC_REG_WR,
        CYC_CAP_RD,
        CYC_PLY_WR
    } cyc_kind_e;
endpackage

// File: rtl/cbi_cycle_track.sv
module cbi_cycle_track
    import cbi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              cs_n,
    input  logic              cap_ack_n,
    input  logic              ply_ack_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output cyc_kind_e         live_kind,
    output logic              drive_en,
    output logic              xcvr_en_n,
    output logic              xcvr_dir,
    output cyc_kind_e         commit_kind,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data
);
    typedef struct packed {
        logic              active;
        logic              illegal;
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } trk_t;

    trk_t trk_d, trk_q;
    logic strobe_any, both_low, dma_ack, sel;

    always_comb begin
        strobe_any = !rd_n || !wr_n;
        both_low   = !rd_n && !wr_n;
        dma_ack    = !cap_ack_n || !ply_ack_n;
        sel        = dma_ack || !cs_n;

        live_kind = CYC_NONE;
        if (!both_low) begin
            if (!cap_ack_n && !rd_n)       live_kind = CYC_CAP_RD;
            else if (!ply_ack_n && !wr_n)  live_kind = CYC_PLY_WR;
            else if (!dma_ack && !cs_n) begin
                if (!rd_n)      live_kind = CYC_REG_RD;
                else if (!wr_n) live_kind = CYC_REG_WR;
            end
        end

        xcvr_en_n = !(strobe_any && sel);
        xcvr_dir  = !(!rd_n && sel);
        drive_en  = (live_kind == CYC_REG_RD) || (live_kind == CYC_CAP_RD);

        trk_d = trk_q;
        if (strobe_any) begin
            trk_d.active  = 1'b1;
            trk_d.illegal = trk_q.illegal || both_low;
            if (!both_low) trk_d.kind = live_kind;
            trk_d.addr    = addr;
            if (!wr_n) trk_d.data = din;
        end else begin
            trk_d.active  = 1'b0;
            trk_d.illegal = 1'b0;
            trk_d.kind    = CYC_NONE;
        end

        commit_kind = (trk_q.active && !strobe_any && !trk_q.illegal) ? trk_q.kind : CYC_NONE;
        commit_addr = trk_q.addr;
        commit_data = trk_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{active: 1'b0, illegal: 1'b0, kind: CYC_NONE, addr: '0, data: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    // R10
    drive_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (!xcvr_dir && !xcvr_en_n));

    // R11
    commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_kind != CYC_NONE) |=> (commit_kind == CYC_NONE));
endmodule

// File: rtl/cbi_capture_buf.sv
module cbi_capture_buf #(
    parameter int DATA_W = 8,
    parameter int BYTES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [DATA_W*BYTES-1:0] smp_data,
    input  logic                    rd_commit,
    input  logic                    ovr_clr,
    output logic                    req,
    output logic [DATA_W-1:0]       rd_byte,
    output logic                    ovr
);
    localparam int SMP_W = DATA_W * BYTES;
    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

    typedef struct packed {
        logic [SMP_W-1:0] buf_w;
        logic [IDX_W-1:0] idx;
        logic             full;
        logic             ovr;
    } cap_t;

    cap_t cap_d, cap_q;
    logic last_read;
    logic [DATA_W-1:0] lane [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lane[g] = cap_q.buf_w[g*DATA_W +: DATA_W];
    end

    always_comb begin
        cap_d     = cap_q;
        last_read = rd_commit && cap_q.full && (cap_q.idx == LAST);
        if (rd_commit && cap_q.full) begin
            if (cap_q.idx == LAST) begin
                cap_d.full = 1'b0;
                cap_d.idx  = '0;
            end else begin
                cap_d.idx = cap_q.idx + 1'b1;
            end
        end
        if (ovr_clr) cap_d.ovr = 1'b0;
        if (smp_valid) begin
            if (cap_q.full && !last_read) cap_d.ovr = 1'b1;
            cap_d.buf_w = smp_data;
            cap_d.idx   = '0;
            cap_d.full  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign req     = cap_q.full;
    assign rd_byte = lane[cap_q.idx];
    assign ovr     = cap_q.ovr;

    // R1
    cap_req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(rd_commit && cap_q.idx == LAST));

    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && req && !rd_commit) |=> (ovr && cap_q.idx == '0));

    // R11
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_commit && !smp_valid) |=> $stable(cap_q.idx));
endmodule

// File: rtl/cbi_playback_buf.sv
module cbi_playback_buf #(
    parameter int DATA_W = 8,
    parameter int BYTES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_commit,
    input  logic [DATA_W-1:0]       wr_byte,
    input  logic                    take,
    output logic                    req,
    output logic                    smp_valid,
    output logic [DATA_W*BYTES-1:0] smp_data
);
    localparam int SMP_W = DATA_W * BYTES;
    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

    typedef struct packed {
        logic [SMP_W-1:0] buf_w;
        logic [IDX_W-1:0] idx;
        logic             full;
    } ply_t;

    ply_t ply_d, ply_q;

    always_comb begin
        ply_d = ply_q;
        if (take && ply_q.full) ply_d.full = 1'b0;
        if (wr_commit && !ply_q.full) begin
            for (int b = 0; b < BYTES; b++) begin
                if (ply_q.idx == IDX_W'(b)) ply_d.buf_w[b*DATA_W +: DATA_W] = wr_byte;
            end
            if (ply_q.idx == LAST) begin
                ply_d.full = 1'b1;
                ply_d.idx  = '0;
            end else begin
                ply_d.idx = ply_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ply_q <= '0;
        else        ply_q <= ply_d;
    end

    assign req       = !ply_q.full;
    assign smp_valid = ply_q.full;
    assign smp_data  = ply_q.buf_w;

    // R3
    ply_req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(take));

    // R12
    ply_full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && smp_valid) |=> $stable(smp_data));
endmodule

// File: rtl/cbi_regfile.sv
module cbi_regfile #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd_addr,
    input  logic [DATA_W-1:0]           status,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        ovr_clr
);
    localparam int ADDR_W = $clog2(NUM_REGS);
    localparam int STORE  = NUM_REGS - 1;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_REGS - 1);

    typedef struct packed {
        logic [STORE*DATA_W-1:0] file;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d    = rf_q;
        ovr_clr = wr_en && (wr_addr == STATUS_ADDR) && wr_data[0];
        if (wr_en && (int'(wr_addr) < STORE)) begin
            rf_d.file[int'(wr_addr)*DATA_W +: DATA_W] = wr_data;
        end
        rd_data = '0;
        if (rd_addr == STATUS_ADDR)     rd_data = status;
        else if (int'(rd_addr) < STORE) rd_data = rf_q.file[int'(rd_addr)*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    // R5
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rf_q.file));
endmodule

// File: rtl/cbi_host_port.sv
module cbi_host_port
    import cbi_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int BYTES    = 4,
    parameter int NUM_REGS = 4,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int SMP_W   = DATA_W * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic              bus_cs_n,
    input  logic              cap_ack_n,
    input  logic              ply_ack_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_dout_en,
    output logic              xcvr_en_n,
    output logic              xcvr_dir,
    output logic              cap_req,
    output logic              ply_req,
    input  logic              cap_smp_valid,
    input  logic [SMP_W-1:0]  cap_smp,
    output logic              ply_smp_valid,
    output logic [SMP_W-1:0]  ply_smp,
    input  logic              ply_take
);
    cyc_kind_e         live_kind, commit_kind;
    logic              drive_en, ovr, ovr_clr;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data, cap_byte, reg_rd;

    cbi_cycle_track #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_track (
        .clk(clk), .rst_n(rst_n), .rd_n(bus_rd_n), .wr_n(bus_wr_n), .cs_n(bus_cs_n),
        .cap_ack_n(cap_ack_n), .ply_ack_n(ply_ack_n), .addr(bus_addr), .din(host_din),
        .live_kind(live_kind), .drive_en(drive_en), .xcvr_en_n(xcvr_en_n),
        .xcvr_dir(xcvr_dir), .commit_kind(commit_kind), .commit_addr(commit_addr),
        .commit_data(commit_data)
    );

    cbi_capture_buf #(.DATA_W(DATA_W), .BYTES(BYTES)) u_cap (
        .clk(clk), .rst_n(rst_n), .smp_valid(cap_smp_valid), .smp_data(cap_smp),
        .rd_commit(commit_kind == CYC_CAP_RD), .ovr_clr(ovr_clr),
        .req(cap_req), .rd_byte(cap_byte), .ovr(ovr)
    );

    cbi_playback_buf #(.DATA_W(DATA_W), .BYTES(BYTES)) u_ply (
        .clk(clk), .rst_n(rst_n), .wr_commit(commit_kind == CYC_PLY_WR),
        .wr_byte(commit_data), .take(ply_take), .req(ply_req),
        .smp_valid(ply_smp_valid), .smp_data(ply_smp)
    );

    cbi_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(commit_kind == CYC_REG_WR),
        .wr_addr(commit_addr), .wr_data(commit_data), .rd_addr(bus_addr),
        .status({{(DATA_W-1){1'b0}}, ovr}), .rd_data(reg_rd), .ovr_clr(ovr_clr)
    );

    always_comb begin
        host_dout_en = drive_en;
        host_dout    = '0;
        if (drive_en) host_dout = (live_kind == CYC_CAP_RD) ? cap_byte : reg_rd;
    end

    // R8
    xcvr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_n && bus_wr_n) |-> (xcvr_en_n && xcvr_dir && !host_dout_en));

    // R10
    no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> !host_dout_en);
endmodule

// File: tb/cbi_host_port_bench.sv
module cbi_host_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_cs_n = 1'b1;
    logic        cap_ack_n = 1'b1, ply_ack_n = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  host_din = '0;
    logic [7:0]  host_dout;
    logic        host_dout_en, xcvr_en_n, xcvr_dir, cap_req, ply_req;
    logic        cap_smp_valid = 1'b0;
    logic [31:0] cap_smp = '0;
    logic        ply_smp_valid;
    logic [31:0] ply_smp;
    logic        ply_take = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cbi_host_port u_cbi_host_port (
        .clk(clk), .rst_n(rst_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_cs_n(bus_cs_n), .cap_ack_n(cap_ack_n), .ply_ack_n(ply_ack_n),
        .bus_addr(bus_addr), .host_din(host_din), .host_dout(host_dout),
        .host_dout_en(host_dout_en), .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir),
        .cap_req(cap_req), .ply_req(ply_req), .cap_smp_valid(cap_smp_valid),
        .cap_smp(cap_smp), .ply_smp_valid(ply_smp_valid), .ply_smp(ply_smp),
        .ply_take(ply_take)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One bus cycle: strobes low for two clocks, outputs sampled in the middle,
    // committed effects visible when the task returns.
    task automatic bus_cycle(input bit rd, input bit wr, input bit cs, input bit cack,
                             input bit pack, input logic [1:0] a, input logic [7:0] wd,
                             output logic [7:0] dout, output logic oe,
                             output logic en_n, output logic dir);
        @(negedge clk);
        bus_cs_n = !cs; cap_ack_n = !cack; ply_ack_n = !pack;
        bus_addr = a; host_din = wd;
        bus_rd_n = !rd; bus_wr_n = !wr;
        @(negedge clk);
        dout = host_dout; oe = host_dout_en; en_n = xcvr_en_n; dir = xcvr_dir;
        @(negedge clk);
        bus_rd_n = 1'b1; bus_wr_n = 1'b1;
        @(negedge clk);
        bus_cs_n = 1'b1; cap_ack_n = 1'b1; ply_ack_n = 1'b1;
    endtask

    task automatic push_cap(input logic [31:0] s);
        @(negedge clk);
        cap_smp = s; cap_smp_valid = 1'b1;
        @(negedge clk);
        cap_smp_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cap_req after reset", cap_req, 0);
        chk("R3 ply_req after reset", ply_req, 1);
        chk("R3 ply_smp_valid after reset", ply_smp_valid, 0);
        chk("R8 xcvr_en_n idle", xcvr_en_n, 1);
        chk("R9 xcvr_dir idle", xcvr_dir, 1);
        chk("R10 dout_en idle", host_dout_en, 0);
    endtask

    task automatic t_regs();
        logic [7:0] d; logic oe, en, dir;
        bus_cycle(0, 1, 1, 0, 0, 2'd0, 8'hA5, d, oe, en, dir);
        chk("R8 en_n low on reg write", en, 0);
        chk("R9 dir high on reg write", dir, 1);
        chk("R10 no drive on reg write", oe, 0);
        bus_cycle(0, 1, 1, 0, 0, 2'd1, 8'h3C, d, oe, en, dir);
        bus_cycle(0, 1, 1, 0, 0, 2'd2, 8'hF0, d, oe, en, dir);
        bus_cycle(1, 0, 1, 0, 0, 2'd0, 8'h00, d, oe, en, dir);
        chk("R5 reg0 readback", d, 8'hA5);
        chk("R10 drive on reg read", oe, 1);
        chk("R8 en_n low on reg read", en, 0);
        chk("R9 dir low on reg read", dir, 0);
        bus_cycle(1, 0, 1, 0, 0, 2'd2, 8'h00, d, oe, en, dir);
        chk("R5 reg2 readback", d, 8'hF0);
        // write without chip select is ignored
        bus_cycle(0, 1, 0, 0, 0, 2'd1, 8'hFF, d, oe, en, dir);
        chk("R8 en_n high without cs", en, 1);
        bus_cycle(1, 0, 1, 0, 0, 2'd1, 8'h00, d, oe, en, dir);
        chk("R4 reg1 unchanged by cs-high write", d, 8'h3C);
        bus_cycle(1, 0, 0, 0, 0, 2'd1, 8'h00, d, oe, en, dir);
        chk("R4 no drive on read without cs", oe, 0);
        chk("R9 dir high on read without cs", dir, 1);
    endtask

    task automatic t_capture();
        logic [7:0] d; logic oe, en, dir;
        logic [31:0] s = 32'h4433_2211;
        push_cap(s);
        chk("R1 cap_req rises", cap_req, 1);
        for (int k = 0; k < 4; k++) begin
            bus_cycle(1, 0, 0, 1, 0, 2'd0, 8'h00, d, oe, en, dir);
            chk("R2 capture byte", d, s[8*k +: 8]);
            chk("R4 dma read drives with cs high", oe, 1);
            chk("R8 en_n low on dma read", en, 0);
            chk("R9 dir low on dma read", dir, 0);
            chk("R1 cap_req during sample", cap_req, (k < 3) ? 1 : 0);
        end
    endtask

    task automatic t_overrun();
        logic [7:0] d; logic oe, en, dir;
        push_cap(32'hDDCC_BBAA);
        bus_cycle(1, 0, 0, 1, 0, 2'd0, 8'h00, d, oe, en, dir);
        chk("R2 first byte of A", d, 8'hAA);
        push_cap(32'h8765_4321);
        bus_cycle(1, 0, 1, 0, 0, 2'd3, 8'h00, d, oe, en, dir);
        chk("R6 R7 status shows overrun", d, 8'h01);
        for (int k = 0; k < 4; k++) begin
            bus_cycle(1, 0, 0, 1, 0, 2'd0, 8'h00, d, oe, en, dir);
            chk("R7 new sample read from byte 0", d, 32'h8765_4321 >> (8*k) & 32'hFF);
        end
        chk("R1 cap_req low after new sample", cap_req, 0);
        bus_cycle(0, 1, 1, 0, 0, 2'd3, 8'h01, d, oe, en, dir);
        bus_cycle(1, 0, 1, 0, 0, 2'd3, 8'h00, d, oe, en, dir);
        chk("R6 overrun cleared", d, 8'h00);
    endtask

    task automatic t_playback();
        logic [7:0] d; logic oe, en, dir;
        for (int k = 0; k < 4; k++) begin
            bus_cycle(0, 1, 0, 0, 1, 2'd0, 8'h10 * (k + 1), d, oe, en, dir);
            chk("R3 ply_req while filling", ply_req, (k < 3) ? 1 : 0);
            if (k == 0) begin
                chk("R8 en_n low on dma write", en, 0);
                chk("R10 no drive on dma write", oe, 0);
            end
        end
        chk("R3 ply_smp_valid", ply_smp_valid, 1);
        chk("R3 ply_smp assembly", ply_smp, 32'h4030_2010);
        bus_cycle(0, 1, 0, 0, 1, 2'd0, 8'h99, d, oe, en, dir);
        chk("R12 write while full ignored", ply_smp, 32'h4030_2010);
        @(negedge clk); ply_take = 1'b1;
        @(negedge clk); ply_take = 1'b0;
        chk("R3 ply_req after take", ply_req, 1);
        chk("R3 ply_smp_valid after take", ply_smp_valid, 0);
    endtask

    task automatic t_illegal();
        logic [7:0] d; logic oe, en, dir;
        bus_cycle(1, 1, 1, 0, 0, 2'd0, 8'h77, d, oe, en, dir);
        chk("R11 no drive with both strobes", oe, 0);
        bus_cycle(1, 0, 1, 0, 0, 2'd0, 8'h00, d, oe, en, dir);
        chk("R11 reg0 unchanged", d, 8'hA5);
        push_cap(32'h0403_0201);
        bus_cycle(1, 1, 0, 1, 0, 2'd0, 8'h00, d, oe, en, dir);
        chk("R11 cap_req held", cap_req, 1);
        bus_cycle(1, 0, 0, 1, 0, 2'd0, 8'h00, d, oe, en, dir);
        chk("R11 byte counter not advanced", d, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_capture();
        t_overrun();
        t_playback();
        t_illegal();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule